// File: doc/BRIEF.md
# Inbound PCIe Window Address Remapper

This block sits between the inbound side of a PCIe root port and the system interconnect. It translates the addresses of bus-master requests into CPU system addresses. One power-of-two window, given by a base register and a 3-bit size code, decides which bus addresses are accepted. The window is split into eight equal sub-regions. Each sub-region has its own programmable target base in CPU space, so eight separate slices of system memory can be exposed through one window. Any request whose address lies outside the window is consumed and dropped. The drop is flagged with a one-cycle pulse and counted in a saturating counter.

Requests pass through a single registered stage with valid/ready handshakes on both sides. A small synchronous register port sets the window size, the window base and the eight targets, and can read them back. After reset the block maps the default window onto itself, so bus address X reaches CPU address X.

Top module: `pcie_inbound_remap`

## Requirements
- R1: After reset the size code is 0, the window base reads 0x8000_0000, region k's target reads 0x8000_0000 + k·2^20, the miss counter reads 0, and out_valid and miss_pulse are low.
- R2: With size code i, the window covers 2^(23+i) bytes. An address is inside the window when all of its bits at position 23+i and above equal those of the window base.
- R3: The bits of the window base below position 23+i are ignored. They read back as zero and have no effect on the window test.
- R4: The sub-region index of an accepted address is its bit field [22+i:20+i].
- R5: The forwarded address takes bits [31:20+i] from the selected region's target and bits [19+i:0] from the inbound address, unchanged.
- R6: The bits of each region target below position 20+i are ignored and read back as zero.
- R7: A request outside the window is accepted and not forwarded. In the next cycle miss_pulse is high for exactly one cycle and the miss counter has increased by one.
- R8: The miss counter saturates at 0xFFFF.
- R9: An accepted in-window request appears on out_valid/out_addr one cycle after acceptance. While out_valid is high and out_ready is low, out_addr holds steady and in_ready is low.
- R10: The configuration offsets on cfg_addr are: 0 = size code in bits [2:0]; 1 = window base; 2 = miss counter, read-only, with writes ignored; 8+k = target of region k. cfg_rdata is combinational from cfg_addr, and a write takes effect at the clock edge while cfg_we is high.
- R11: Without reprogramming the targets, every in-window address under size code 0 is forwarded unchanged (identity mapping).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inbound request valid |
| in_ready | output | 1 | Inbound request accepted when high with in_valid |
| in_addr | input | 32 | Inbound bus address |
| out_valid | output | 1 | Translated request valid |
| out_ready | input | 1 | System side ready |
| out_addr | output | 32 | Translated CPU address |
| miss_pulse | output | 1 | One-cycle flag for a dropped request |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |

## Verification
Every cycle, the assertions check four things. The output is held under backpressure. The reset leaves the block idle. Offset bits pass from the accepted address to the output. The miss pulse and the miss counter move together, including saturation, and a dropped request never produces an output. Some behaviours only the bench scenarios can show: the window test under each size code, the choice of sub-region, the masking of the base and target low bits, the register map with its read-only counter, and the identity default. The bench checks these against a reference model that it keeps from its own configuration writes.

// File: rtl/pir_pkg.sv
package pir_pkg;
    localparam int ADDR_W       = 32;
    localparam int REGION_CNT   = 8;
    localparam int REGION_IDX_W = $clog2(REGION_CNT);
    localparam int SIZE_CODE_W  = 3;
    localparam int WIN_LOG2_MIN = 23;
    localparam int SUB_LOG2_MIN = WIN_LOG2_MIN - REGION_IDX_W;
    localparam int CFG_ADDR_W   = 4;
    localparam logic [ADDR_W-1:0] RESET_WIN_BASE = 32'h8000_0000;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [SIZE_CODE_W-1:0] size_code_t;
    typedef logic [REGION_IDX_W-1:0] region_idx_t;

    typedef enum logic [CFG_ADDR_W-1:0] {
        CFG_CTRL = 4'd0,
        CFG_BASE = 4'd1,
        CFG_MISS = 4'd2
    } cfg_sel_e;

    typedef struct packed {
        logic        hit;
        region_idx_t idx;
        addr_t       xaddr;
    } xlate_t;

    // Bits kept from the window base when testing for a hit.
    function automatic addr_t win_keep_mask(size_code_t code);
        return addr_t'({ADDR_W{1'b1}} << (WIN_LOG2_MIN + int'(code)));
    endfunction

    // Bits taken from the region target; the rest is the offset.
    function automatic addr_t sub_keep_mask(size_code_t code);
        return addr_t'({ADDR_W{1'b1}} << (SUB_LOG2_MIN + int'(code)));
    endfunction
endpackage

// File: rtl/pir_cfg_regs.sv
module pir_cfg_regs
    import pir_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  addr_t                 cfg_wdata,
    output addr_t                 cfg_rdata,
    input  logic [CNT_W-1:0]      miss_count,
    output size_code_t            size_code,
    output addr_t                 win_base,
    output addr_t                 region_tgt [REGION_CNT]
);
    size_code_t size_q;
    addr_t      base_q;
    addr_t      tgt_q [REGION_CNT];

    always_ff @(posedge clk) begin
        if (rst) begin
            size_q <= '0;
            base_q <= RESET_WIN_BASE;
            for (int k = 0; k < REGION_CNT; k++) begin
                tgt_q[k] <= RESET_WIN_BASE + (addr_t'(k) << SUB_LOG2_MIN);
            end
        end else if (cfg_we) begin
            if (cfg_addr[CFG_ADDR_W-1]) begin
                tgt_q[cfg_addr[REGION_IDX_W-1:0]] <= cfg_wdata;
            end else begin
                case (cfg_addr)
                    CFG_CTRL: size_q <= cfg_wdata[SIZE_CODE_W-1:0];
                    CFG_BASE: base_q <= cfg_wdata;
                    default:  ;
                endcase
            end
        end
    end

    assign size_code = size_q;
    assign win_base  = base_q & win_keep_mask(size_q);

    for (genvar g = 0; g < REGION_CNT; g++) begin : g_tgt
        assign region_tgt[g] = tgt_q[g] & sub_keep_mask(size_q);
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr[CFG_ADDR_W-1]) begin
            cfg_rdata = region_tgt[cfg_addr[REGION_IDX_W-1:0]];
        end else begin
            case (cfg_addr)
                CFG_CTRL: cfg_rdata = addr_t'(size_q);
                CFG_BASE: cfg_rdata = win_base;
                CFG_MISS: cfg_rdata = addr_t'(miss_count);
                default:  cfg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pir_xlate.sv
module pir_xlate
    import pir_pkg::*;
(
    input  addr_t      in_addr,
    input  size_code_t size_code,
    input  addr_t      win_base,
    input  addr_t      region_tgt [REGION_CNT],
    output xlate_t     result
);
    addr_t win_mask;
    addr_t sub_mask;
    addr_t shifted;

    always_comb begin
        win_mask      = win_keep_mask(size_code);
        sub_mask      = sub_keep_mask(size_code);
        shifted       = in_addr >> (SUB_LOG2_MIN + int'(size_code));
        result.hit    = ((in_addr ^ win_base) & win_mask) == '0;
        result.idx    = shifted[REGION_IDX_W-1:0];
        result.xaddr  = (region_tgt[result.idx] & sub_mask) | (in_addr & ~sub_mask);
    end
endmodule

// File: rtl/pir_out_stage.sv
module pir_out_stage
    import pir_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  xlate_t           xl,
    output logic             out_valid,
    input  logic             out_ready,
    output addr_t            out_addr,
    output logic             miss_pulse,
    output logic [CNT_W-1:0] miss_count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic  valid_q;
    addr_t addr_q;
    logic  miss_q;
    logic  [CNT_W-1:0] cnt_q;
    logic  accept;

    assign in_ready = !valid_q || out_ready;
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
            miss_q  <= 1'b0;
            cnt_q   <= '0;
        end else begin
            miss_q <= accept && !xl.hit;
            if (accept) begin
                valid_q <= xl.hit;
                if (xl.hit) begin
                    addr_q <= xl.xaddr;
                end else if (cnt_q != CNT_MAX) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else if (out_ready) begin
                valid_q <= 1'b0;
            end
        end
    end

    assign out_valid  = valid_q;
    assign out_addr   = addr_q;
    assign miss_pulse = miss_q;
    assign miss_count = cnt_q;
endmodule

// File: rtl/pcie_inbound_remap.sv
module pcie_inbound_remap
    import pir_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [ADDR_W-1:0]     in_addr,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [ADDR_W-1:0]     out_addr,
    output logic                  miss_pulse,
    input  logic                  cfg_we,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [ADDR_W-1:0]     cfg_wdata,
    output logic [ADDR_W-1:0]     cfg_rdata
);
    size_code_t       size_code;
    addr_t            win_base;
    addr_t            region_tgt [REGION_CNT];
    xlate_t           xl;
    logic [CNT_W-1:0] miss_count;

    pir_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .miss_count (miss_count),
        .size_code  (size_code),
        .win_base   (win_base),
        .region_tgt (region_tgt)
    );

    pir_xlate u_xlate (
        .in_addr    (in_addr),
        .size_code  (size_code),
        .win_base   (win_base),
        .region_tgt (region_tgt),
        .result     (xl)
    );

    pir_out_stage #(.CNT_W(CNT_W)) u_out (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .xl         (xl),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_addr   (out_addr),
        .miss_pulse (miss_pulse),
        .miss_count (miss_count)
    );
endmodule

// File: rtl/pir_checker.sv
module pir_checker
    import pir_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input addr_t            in_addr,
    input logic             out_valid,
    input logic             out_ready,
    input addr_t            out_addr,
    input logic             miss_pulse,
    input size_code_t       size_code,
    input logic [CNT_W-1:0] miss_count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !miss_pulse && miss_count == '0));

    assert_out_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));

    assert_stall_ready_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    assert_offset_pass_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(in_valid && in_ready)) |->
        (((out_addr ^ $past(in_addr)) & ~sub_keep_mask($past(size_code))) == '0));

    assert_miss_no_out_R7: assert property (@(posedge clk) disable iff (rst)
        miss_pulse |-> (!out_valid && $past(in_valid && in_ready)));

    assert_miss_count_R7: assert property (@(posedge clk) disable iff (rst)
        (miss_pulse && $past(miss_count) != CNT_MAX) |-> (miss_count == $past(miss_count) + 1'b1));

    assert_count_still_R7: assert property (@(posedge clk) disable iff (rst)
        !miss_pulse |-> $stable(miss_count));

    assert_miss_sat_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(miss_count) == CNT_MAX) |-> (miss_count == CNT_MAX));
endmodule

bind pcie_inbound_remap pir_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_addr    (in_addr),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_addr   (out_addr),
    .miss_pulse (miss_pulse),
    .size_code  (size_code),
    .miss_count (miss_count)
);

// File: tb/tb_pcie_inbound_remap.sv
module tb_pcie_inbound_remap;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_addr = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_addr;
    logic        miss_pulse;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [2:0]  m_size;
    logic [31:0] m_base;
    logic [31:0] m_tgt [8];
    int          m_miss;

    always #5 clk = ~clk;

    pcie_inbound_remap dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .miss_pulse(miss_pulse),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    function automatic logic [31:0] wmask(logic [2:0] s);
        return 32'hFFFF_FFFF << (23 + int'(s));
    endfunction
    function automatic logic [31:0] smask(logic [2:0] s);
        return 32'hFFFF_FFFF << (20 + int'(s));
    endfunction
    function automatic bit exp_hit(logic [31:0] a);
        return ((a ^ m_base) & wmask(m_size)) == 0;
    endfunction
    function automatic logic [31:0] exp_xl(logic [31:0] a);
        logic [2:0] k;
        k = 3'((a >> (20 + int'(m_size))) & 32'h7);
        return (m_tgt[k] & smask(m_size)) | (a & ~smask(m_size));
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a == 4'd0) m_size = d[2:0];
        else if (a == 4'd1) m_base = d;
        else if (a[3]) m_tgt[a[2:0]] = d;
    endtask

    task automatic cfg_read(logic [3:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    // Single request with out_ready high; result sampled one negedge later.
    task automatic send(string req, logic [31:0] a);
        bit h;
        h = exp_hit(a);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " out_valid"}, 32'(out_valid), 32'(h));
        check({req, " miss_pulse"}, 32'(miss_pulse), 32'(!h));
        if (h) check({req, " out_addr"}, out_addr, exp_xl(a));
        else m_miss++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd12345));
        m_size = 3'd0; m_base = 32'h8000_0000; m_miss = 0;
        for (int k = 0; k < 8; k++) m_tgt[k] = 32'h8000_0000 + (32'(k) << 20);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 out_valid", 32'(out_valid), 0);
        check("R1 miss_pulse", 32'(miss_pulse), 0);
        cfg_read(4'd0, rd); check("R1 size", rd, 0);
        cfg_read(4'd1, rd); check("R1 base", rd, 32'h8000_0000);
        cfg_read(4'd2, rd); check("R1 count", rd, 0);
        for (int k = 0; k < 8; k++) begin
            cfg_read(4'(8 + k), rd);
            check("R1 target", rd, 32'h8000_0000 + (32'(k) << 20));
        end

        // R11 identity under defaults
        send("R11 identity", 32'h8012_3456);
        send("R11 identity top", 32'h807F_FFFC);
        // R2 edge of the default window, R7 miss
        send("R2 below window", 32'h7FFF_FFFF);
        send("R7 above window", 32'h8080_0000);
        cfg_read(4'd2, rd); check("R7 count", rd, 32'(m_miss));

        // R10 miss counter is read-only
        cfg_write(4'd2, 32'h0000_1234);
        cfg_read(4'd2, rd); check("R10 count write ignored", rd, 32'(m_miss));

        // R3/R6 low bits masked on readback
        cfg_write(4'd0, 32'd2);
        cfg_write(4'd1, 32'h4123_4567);
        cfg_read(4'd1, rd); check("R3 base masked", rd, 32'h4000_0000);
        cfg_write(4'd9, 32'h1234_5678);
        cfg_read(4'd9, rd); check("R6 target masked", rd, 32'h1200_0000);
        cfg_read(4'd0, rd); check("R10 size readback", rd, 2);
        // R4 region 1 selected by bits [24:22]
        send("R4 region1", 32'h405A_BCDE);
        send("R3 top of window", 32'h41FF_FFFF);
        send("R2 just past window", 32'h4200_0000);

        // R9 backpressure
        @(negedge clk);
        out_ready = 1'b0; in_valid = 1'b1; in_addr = 32'h4010_0000;
        @(negedge clk);
        in_addr = 32'h41C0_0010;
        check("R9 out_valid", 32'(out_valid), 1);
        check("R9 in_ready low", 32'(in_ready), 0);
        check("R9 first addr", out_addr, exp_xl(32'h4010_0000));
        @(negedge clk);
        check("R9 held addr", out_addr, exp_xl(32'h4010_0000));
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 second addr", out_addr, exp_xl(32'h41C0_0010));
        @(negedge clk);
        check("R9 drained", 32'(out_valid), 0);

        // Random configurations and traffic: R2 R4 R5 R6
        for (int c = 0; c < 12; c++) begin
            cfg_write(4'd0, 32'($urandom_range(0, 7)));
            cfg_write(4'd1, $urandom());
            for (int k = 0; k < 8; k++) cfg_write(4'(8 + k), $urandom());
            for (int t = 0; t < 25; t++) begin
                logic [31:0] a;
                a = $urandom();
                if ($urandom_range(0, 2) != 0)
                    a = (m_base & wmask(m_size)) | (a & ~wmask(m_size));
                send("R5 random", a);
            end
        end
        cfg_read(4'd2, rd); check("R7 count after random", rd, 32'(m_miss));

        // R8 saturation
        cfg_write(4'd0, 32'd0);
        cfg_write(4'd1, 32'h8000_0000);
        @(negedge clk);
        in_valid = 1'b1; in_addr = 32'h0000_0100;
        repeat (66000) @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        cfg_read(4'd2, rd); check("R8 saturated", rd, 32'h0000_FFFF);
        check("R7 pulse ends", 32'(miss_pulse), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule